// File: doc/BRIEF.md
# Indirect Command Bridge to a 32-bit Internal Bus

This block lets a host that only speaks 64-bit register accesses reach a 32-bit internal bus one transfer at a time. The host sees four 8-byte registers. A write to the command register starts one internal read or write. The size and address of that transfer come from the command word. The outcome is then collected from a status word that clears when it is read. Write data is staged beforehand in a data register.

Toward the internal bus the block acts as a simple synchronous master. It holds address, size, write data and a direction flag while `bus_valid` is high. It stays there until the bus answers with `bus_ready` or `bus_error`. Only one transfer is outstanding at any time.

Host reads are answered one cycle after the request, on `hst_rvalid` and `hst_rdata`.

Top module: `ind_bus_bridge`

## Requirements
- R1: The register is chosen by `hst_addr[4:3]`: 0 is command, 1 is reset, 2 is status, 3 is data. Only accesses with `hst_size` = 3 (eight bytes) take effect. Any other size writes nothing, and a read of another size returns zero.
- R2: A command write while no transfer is outstanding raises `bus_valid` on the next cycle. It presents command bits 31:0 as `bus_addr` and bits 59:56 as `bus_size`. `bus_write` is set when command bit 48 is clear, and a set bit 48 means a read.
- R3: Once raised, `bus_valid`, `bus_addr`, `bus_size`, `bus_write` and `bus_wdata` hold steady until `bus_ready` or `bus_error` is seen. A command write arriving in that window is ignored.
- R4: A read that ends with `bus_ready` leaves status equal to the done flag at bit 11 together with `bus_rdata` in bits 57:26.
- R5: A read that ends with `bus_error` leaves status with the done flag and all ones in bits 57:26.
- R6: A write leaves status holding only the done flag (0x800), whether it ended with ready or with error.
- R7: With no transfer outstanding, a status read returns the current status and clears it to zero, so a second read returns zero.
- R8: A status read issued while a transfer is outstanding, including its completion cycle, returns zero and does not disturb the result that follows.
- R9: A data write stores host bits 63:32. A data read returns the stored value in bits 63:32 with zeros in bits 31:0.
- R10: Reads of the command and reset registers return zero. Writes to the reset and status registers change nothing.
- R11: `bus_wdata` carries the data register as captured at launch, with bits 31:24 as the lowest-address byte. On a read, the lowest-address byte arrives on `bus_rdata[31:24]` and lands in status bits 57:50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_valid | input | 1 | Host access request |
| hst_write | input | 1 | 1 = host write, 0 = host read |
| hst_addr | input | HADDR_W | Host byte address; bits 4:3 pick the register |
| hst_size | input | 2 | Access size code, 3 = eight bytes |
| hst_wdata | input | 64 | Host write data |
| hst_rvalid | output | 1 | Read response valid, one cycle after the request |
| hst_rdata | output | 64 | Read response data |
| bus_valid | output | 1 | Internal transfer outstanding |
| bus_write | output | 1 | 1 = internal write |
| bus_addr | output | 32 | Internal address |
| bus_size | output | 4 | Transfer size in bytes |
| bus_wdata | output | 32 | Internal write data, big-endian |
| bus_ready | input | 1 | Transfer completed |
| bus_error | input | 1 | Transfer failed |
| bus_rdata | input | 32 | Internal read data, big-endian |

## Verification
The bench builds the block with the default `HADDR_W` of 8. That width is enough to show the register decode repeating: addresses 0x18 and 0x38 both reach the data register. The bench plays the internal bus itself, so it chooses the exact cycle that ready or error arrives. This lets it place status reads and stray command writes inside a pending transfer and on its completion cycle. It also covers read errors, write errors and non-eight-byte accesses.

// File: rtl/ind_bus_bridge.sv
module ind_bus_bridge #(
  parameter int HADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hst_valid,
  input  logic               hst_write,
  input  logic [HADDR_W-1:0] hst_addr,
  input  logic [1:0]         hst_size,
  input  logic [63:0]        hst_wdata,
  output logic               hst_rvalid,
  output logic [63:0]        hst_rdata,
  output logic               bus_valid,
  output logic               bus_write,
  output logic [31:0]        bus_addr,
  output logic [3:0]         bus_size,
  output logic [31:0]        bus_wdata,
  input  logic               bus_ready,
  input  logic               bus_error,
  input  logic [31:0]        bus_rdata
);
  localparam logic [1:0] SEL_CMD  = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd2;
  localparam logic [1:0] SEL_DATA = 2'd3;
  localparam logic [1:0] FULL     = 2'd3;
  localparam int DONE_BIT = 11;
  localparam int RD_LSB   = 26;
  localparam int DIR_BIT  = 48;

  logic [31:0] data_q;
  logic [63:0] stat_q;
  logic [63:0] rd_val;
  logic [63:0] result;
  logic [31:0] rd_field;
  logic [1:0]  sel;
  logic        full_acc, host_rd, finish;

  assign sel      = hst_addr[4:3];
  assign full_acc = hst_valid && (hst_size == FULL);
  assign host_rd  = full_acc && !hst_write;
  assign finish   = bus_valid && (bus_ready || bus_error);
  assign rd_field = bus_write ? 32'h0 : (bus_error ? 32'hFFFF_FFFF : bus_rdata);
  assign result   = (64'(1) << DONE_BIT) | (64'(rd_field) << RD_LSB);

  always_comb begin
    rd_val = '0;
    if (host_rd) begin
      case (sel)
        SEL_STAT: rd_val = bus_valid ? 64'h0 : stat_q;
        SEL_DATA: rd_val = {data_q, 32'h0};
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hst_rvalid <= 1'b0;
      hst_rdata  <= '0;
      bus_valid  <= 1'b0;
      bus_write  <= 1'b0;
      bus_addr   <= '0;
      bus_size   <= '0;
      bus_wdata  <= '0;
      data_q     <= '0;
      stat_q     <= '0;
    end else begin
      hst_rvalid <= hst_valid && !hst_write;
      if (hst_valid && !hst_write) hst_rdata <= rd_val;
      if (full_acc && hst_write && sel == SEL_DATA) data_q <= hst_wdata[63:32];
      if (finish) begin
        bus_valid <= 1'b0;
        stat_q    <= result;
      end else if (host_rd && sel == SEL_STAT && !bus_valid) begin
        stat_q <= '0;
      end
      if (full_acc && hst_write && sel == SEL_CMD && !bus_valid) begin
        bus_valid <= 1'b1;
        bus_write <= !hst_wdata[DIR_BIT];
        bus_addr  <= hst_wdata[31:0];
        bus_size  <= hst_wdata[59:56];
        bus_wdata <= data_q;
      end
    end
  end
endmodule

// File: rtl/ind_bus_bridge_chk.sv
module ind_bus_bridge_chk #(
  parameter int HADDR_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hst_valid,
  input logic               hst_write,
  input logic [HADDR_W-1:0] hst_addr,
  input logic [1:0]         hst_size,
  input logic [63:0]        hst_rdata,
  input logic               bus_valid,
  input logic               bus_write,
  input logic [31:0]        bus_addr,
  input logic [3:0]         bus_size,
  input logic [31:0]        bus_wdata,
  input logic               bus_ready,
  input logic               bus_error
);
  logic rd_full;
  assign rd_full = hst_valid && !hst_write && hst_size == 2'd3;

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready && !bus_error |=>
      bus_valid && $stable(bus_addr) && $stable(bus_size) && $stable(bus_write) && $stable(bus_wdata));

  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid && hst_valid && hst_write && hst_size == 2'd3 && hst_addr[4:3] == 2'd0 |=> bus_valid);

  a_r8_busy_stat_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_full && hst_addr[4:3] == 2'd2 && bus_valid |=> hst_rdata == 64'h0);

  a_r10_cmd_rst_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_full && !hst_addr[4] |=> hst_rdata == 64'h0);

  a_r9_data_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_full && hst_addr[4:3] == 2'd3 |=> hst_rdata[31:0] == 32'h0);

  a_r1_bad_size_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hst_valid && !hst_write && hst_size != 2'd3 |=> hst_rdata == 64'h0);
endmodule

bind ind_bus_bridge ind_bus_bridge_chk #(.HADDR_W(HADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_valid(hst_valid), .hst_write(hst_write),
  .hst_addr(hst_addr), .hst_size(hst_size), .hst_rdata(hst_rdata),
  .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
  .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
  .bus_error(bus_error)
);

// File: tb/test_ind_bus_bridge.sv
module test_ind_bus_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 8;

  logic clk = 0, rst_n = 0;
  logic hst_valid = 0, hst_write = 0;
  logic [HW-1:0] hst_addr = '0;
  logic [1:0] hst_size = 2'd3;
  logic [63:0] hst_wdata = '0;
  logic hst_rvalid;
  logic [63:0] hst_rdata;
  logic bus_valid, bus_write;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0] bus_size;
  logic bus_ready = 0, bus_error = 0;
  logic [31:0] bus_rdata = '0;

  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ind_bus_bridge #(.HADDR_W(HW)) i_ind_bus_bridge (.*);

  // behavioural reference model
  bit m_busy, m_wr, m_rv;
  bit [63:0] m_stat, m_rd;
  bit [31:0] m_data;

  always @(posedge clk) begin
    automatic bit full = hst_valid && hst_size == 3;
    automatic int r = hst_addr[4:3];
    automatic bit [63:0] v = 0;
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_wr = 0; m_rv = 0; m_stat = 0; m_rd = 0; m_data = 0;
    end else begin
      if (full && !hst_write && r == 2) v = m_busy ? 0 : m_stat;
      if (full && !hst_write && r == 3) v = {m_data, 32'h0};
      m_rv = hst_valid && !hst_write;
      if (m_rv) m_rd = v;
      if (full && !hst_write && r == 2 && !m_busy) m_stat = 0;
      if (full && hst_write && r == 3) m_data = hst_wdata[63:32];
      if (m_busy && (bus_ready || bus_error)) begin
        m_busy = 0;
        m_stat = 64'h800;
        if (!m_wr) m_stat = m_stat | ({32'h0, bus_error ? 32'hFFFF_FFFF : bus_rdata} << 26);
      end else if (!m_busy && full && hst_write && r == 0) begin
        m_busy = 1;
        m_wr = !hst_wdata[48];
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (hst_rvalid !== m_rv || bus_valid !== m_busy || (m_rv && hst_rdata !== m_rd)) begin
      errors++;
      $display("FAIL model(R1/R4/R7/R8/R9) rvalid=%0b busy=%0b rdata=%h expected rvalid=%0b busy=%0b rdata=%h",
               hst_rvalid, bus_valid, hst_rdata, m_rv, m_busy, m_rd);
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [HW-1:0] a, input logic [63:0] d, input logic [1:0] sz = 2'd3);
    hst_valid = 1; hst_write = 1; hst_addr = a; hst_wdata = d; hst_size = sz;
    @(posedge clk); @(negedge clk);
    hst_valid = 0; hst_write = 0; hst_size = 2'd3;
  endtask

  task automatic hrd(input logic [HW-1:0] a, output logic [63:0] d, input logic [1:0] sz = 2'd3);
    hst_valid = 1; hst_write = 0; hst_addr = a; hst_size = sz;
    @(posedge clk); @(negedge clk);
    d = hst_rdata;
    hst_valid = 0; hst_size = 2'd3;
  endtask

  task automatic resp(input logic err, input logic [31:0] rd);
    bus_ready = !err; bus_error = err; bus_rdata = rd;
    @(posedge clk); @(negedge clk);
    bus_ready = 0; bus_error = 0;
  endtask

  localparam logic [HW-1:0] A_CMD = 8'h00, A_RST = 8'h08, A_STAT = 8'h10, A_DATA = 8'h18;
  localparam logic [63:0] RD_BIT = 64'h0001_0000_0000_0000;

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R2 reset bus_valid", 64'(bus_valid), 0);
    chk("R1 reset rvalid", 64'(hst_rvalid), 0);
    hrd(A_STAT, d); chk("R7 status after reset", d, 0);

    hwr(A_DATA, 64'hDEAD_BEEF_1234_5678);
    hrd(A_DATA, d); chk("R9 data readback", d, 64'hDEAD_BEEF_0000_0000);
    hrd(8'h38, d); chk("R1 decode alias 0x38", d, 64'hDEAD_BEEF_0000_0000);
    hrd(A_CMD, d); chk("R10 command reads zero", d, 0);
    hrd(A_RST, d); chk("R10 reset reads zero", d, 0);
    hwr(A_RST, 64'hFFFF_FFFF_FFFF_FFFF);
    hwr(A_STAT, 64'hFFFF_FFFF_FFFF_FFFF);
    hrd(A_STAT, d); chk("R10 status write ignored", d, 0);
    hrd(A_DATA, d); chk("R10 reset write ignored", d, 64'hDEAD_BEEF_0000_0000);
    hwr(A_DATA, 64'h1111_1111_0000_0000, 2'd2);
    hrd(A_DATA, d); chk("R1 short write ignored", d, 64'hDEAD_BEEF_0000_0000);
    hrd(A_DATA, d, 2'd1); chk("R1 short read zero", d, 0);
    hwr(A_CMD, 64'h0, 2'd0);
    chk("R1 short command no launch", 64'(bus_valid), 0);

    // read transfer
    hwr(A_CMD, 64'h0400_0000_1234_5678 | RD_BIT);
    chk("R2 launch valid", 64'(bus_valid), 1);
    chk("R2 direction read", 64'(bus_write), 0);
    chk("R2 address", 64'(bus_addr), 64'h1234_5678);
    chk("R2 size", 64'(bus_size), 4);
    hwr(A_CMD, 64'h0100_0000_0000_00AA);
    chk("R3 busy command ignored addr", 64'(bus_addr), 64'h1234_5678);
    chk("R3 busy command ignored size", 64'(bus_size), 4);
    hrd(A_STAT, d); chk("R8 status read while busy", d, 0);
    resp(0, 32'hA1B2_C3D4);
    chk("R3 valid drops after ready", 64'(bus_valid), 0);
    hrd(A_STAT, d); chk("R4 R11 read result", d, 64'h800 | (64'hA1B2_C3D4 << 26));
    chk("R11 first byte in 57:50", 64'(d[57:50]), 64'hA1);
    hrd(A_STAT, d); chk("R7 status cleared", d, 0);

    // status read on completion cycle
    hwr(A_CMD, 64'h0200_0000_0000_0040 | RD_BIT);
    hst_valid = 1; hst_write = 0; hst_addr = A_STAT;
    bus_ready = 1; bus_rdata = 32'h0102_0304;
    @(posedge clk); @(negedge clk);
    d = hst_rdata;
    hst_valid = 0; bus_ready = 0;
    chk("R8 completion-cycle read zero", d, 0);
    hrd(A_STAT, d); chk("R8 result preserved", d, 64'h800 | (64'h0102_0304 << 26));

    // read error
    hwr(A_CMD, 64'h0100_0000_0000_0010 | RD_BIT);
    repeat (3) @(negedge clk);
    chk("R3 valid held while waiting", 64'(bus_valid), 1);
    resp(1, 32'h5555_5555);
    hrd(A_STAT, d); chk("R5 read error ones", d, 64'h800 | (64'hFFFF_FFFF << 26));

    // write transfers
    hwr(A_DATA, 64'hCAFE_F00D_0000_0000);
    hwr(A_CMD, 64'h0400_0000_0000_0100);
    chk("R2 direction write", 64'(bus_write), 1);
    chk("R11 write data", 64'(bus_wdata), 64'hCAFE_F00D);
    hwr(A_DATA, 64'h0BAD_0BAD_0000_0000);
    chk("R3 wdata held", 64'(bus_wdata), 64'hCAFE_F00D);
    resp(1, 32'h0);
    hrd(A_STAT, d); chk("R6 write error done only", d, 64'h800);
    hwr(A_CMD, 64'h0400_0000_0000_0104);
    chk("R11 new wdata", 64'(bus_wdata), 64'h0BAD_0BAD);
    resp(0, 32'hFFFF_FFFF);
    hrd(A_STAT, d); chk("R6 write ok done only", d, 64'h800);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule